// File: doc/BRIEF.md
# Flag-Setting Data-Processing ALU

This block is the purely combinational arithmetic and logic stage of a 32-bit integer datapath. It takes a first operand straight from the register file and a second operand that has already passed through the barrel shifter, together with a 4-bit operation code. From these it produces the result and a strobe that says whether the result should be written back. It also produces candidate Negative, Zero, Carry and oVerflow flags, which the surrounding pipeline may or may not commit.

The stored carry and overflow flags come in as inputs, and so does the carry-out of the shifter. Add-with-carry and subtract-with-carry use the stored carry. Logical operations pass the shifter carry through to the carry flag and leave overflow at its stored value. After any subtraction the carry flag means "no borrow", so the carry can chain multi-word subtractions in the same way it chains additions. The four comparison and test codes compute flags exactly like their arithmetic or logical counterparts but suppress the write-back.

Top module: `dp_alu`

## Requirements
- R1: Codes 0, 1 and 12 produce the bitwise AND, XOR and OR of the two operands.
- R2: Code 13 passes the second operand, code 15 outputs its bitwise inverse, and code 14 clears each first-operand bit where the second operand holds a one.
- R3: Code 4 adds the operands and code 5 adds the operands plus the carry input. In both, the carry flag is the unsigned carry-out of bit 31.
- R4: Code 2 computes first minus second, and code 3 computes second minus first. Code 6 computes first minus second minus (1 − carry input), and code 7 does the same with the operands swapped. In all four, the carry flag is 1 when no borrow occurred and 0 when one did.
- R5: For codes 2–7, 10 and 11, the overflow flag is 1 exactly when the exact signed result does not fit in 32 bits.
- R6: For every code, the negative flag equals bit 31 of the result, and the zero flag is 1 exactly when the result is all zeros.
- R7: For codes 0, 1, 8, 9 and 12–15, the carry flag equals the shifter carry-out input, and the overflow flag equals the overflow input.
- R8: Codes 8, 9, 10 and 11 compute the result and flags of AND, XOR, subtract and add respectively, with the write strobe low. All other codes drive the write strobe high.
- R9: An add on the low words followed by an add-with-carry on the high words, fed with the first carry, gives the correct 64-bit sum. The same holds for subtract followed by subtract-with-carry and the 64-bit difference.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 32 | First operand, from a register |
| opb_i | input | 32 | Second operand, already shifted |
| op_i | input | 4 | Operation code |
| c_i | input | 1 | Stored carry flag |
| v_i | input | 1 | Stored overflow flag |
| shc_i | input | 1 | Carry-out of the barrel shifter |
| res_o | output | 32 | Operation result |
| wr_o | output | 1 | Result write-back enable |
| n_o | output | 1 | Candidate negative flag |
| z_o | output | 1 | Candidate zero flag |
| c_o | output | 1 | Candidate carry flag |
| v_o | output | 1 | Candidate overflow flag |

## Verification
The bench targets the carry sense after subtraction. A design that reported a true borrow instead of "no borrow" would flip the carry flag on every subtract and compare, and chained 64-bit differences would go wrong. It drives the signed boundaries 0x7FFFFFFF+1 and 0x80000000−1, where a wrong overflow formula shows up at once. It also drives the swapped reverse forms with asymmetric operands, which exposes an unswapped subtractor. Finally it checks that compare and test codes keep the write strobe low while still producing flags, and that logical codes take the shifter carry rather than the adder carry-out.

// File: rtl/dp_alu.sv
module dp_alu #(
  parameter int W = 32
) (
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic [3:0]   op_i,
  input  logic         c_i,
  input  logic         v_i,
  input  logic         shc_i,
  output logic [W-1:0] res_o,
  output logic         wr_o,
  output logic         n_o,
  output logic         z_o,
  output logic         c_o,
  output logic         v_o
);

  localparam logic [3:0] OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3;
  localparam logic [3:0] OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7;
  localparam logic [3:0] OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11;
  localparam logic [3:0] OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15;

  logic         arith;
  logic [W-1:0] ax, ay, lres;
  logic         acin;
  logic [W:0]   asum;
  logic         aovf;

  always_comb begin
    arith = 1'b1;
    ax    = opa_i;
    ay    = opb_i;
    acin  = 1'b0;
    lres  = '0;
    unique case (op_i)
      OP_SUB, OP_CMP: begin ay = ~opb_i; acin = 1'b1; end
      OP_RSB:         begin ax = opb_i; ay = ~opa_i; acin = 1'b1; end
      OP_ADD, OP_CMN: acin = 1'b0;
      OP_ADC:         acin = c_i;
      OP_SBC:         begin ay = ~opb_i; acin = c_i; end
      OP_RSC:         begin ax = opb_i; ay = ~opa_i; acin = c_i; end
      OP_AND, OP_TST: begin arith = 1'b0; lres = opa_i & opb_i; end
      OP_EOR, OP_TEQ: begin arith = 1'b0; lres = opa_i ^ opb_i; end
      OP_ORR:         begin arith = 1'b0; lres = opa_i | opb_i; end
      OP_MOV:         begin arith = 1'b0; lres = opb_i; end
      OP_BIC:         begin arith = 1'b0; lres = opa_i & ~opb_i; end
      default:        begin arith = 1'b0; lres = ~opb_i; end
    endcase
  end

  assign asum  = {1'b0, ax} + {1'b0, ay} + {{W{1'b0}}, acin};
  assign aovf  = (ax[W-1] == ay[W-1]) && (asum[W-1] != ax[W-1]);

  assign res_o = arith ? asum[W-1:0] : lres;
  assign c_o   = arith ? asum[W] : shc_i;
  assign v_o   = arith ? aovf : v_i;
  assign n_o   = res_o[W-1];
  assign z_o   = (res_o == '0);
  assign wr_o  = (op_i[3:2] != 2'b10);

  always_comb begin
    if (op_i == OP_ADD)
      p_add_carry_r3: assert ({c_o, res_o} == {1'b0, opa_i} + {1'b0, opb_i})
        else $error("add carry mismatch");
    if (op_i == OP_SUB || op_i == OP_CMP)
      p_sub_noborrow_r4: assert (c_o == (opa_i >= opb_i) && res_o == opa_i - opb_i)
        else $error("subtract borrow sense mismatch");
    if (op_i == OP_ADD || op_i == OP_CMN)
      p_add_ovf_r5: assert (v_o == ((opa_i[W-1] == opb_i[W-1]) && (res_o[W-1] != opa_i[W-1])))
        else $error("add overflow mismatch");
    if (op_i == OP_BIC)
      p_bic_r2: assert ((res_o & opb_i) == '0)
        else $error("clear-bits left a masked bit set");
    if (op_i[3:2] == 2'b11 || op_i[3:1] == 3'b000 || op_i[3:1] == 3'b100)
      p_logic_flags_r7: assert (c_o == shc_i && v_o == v_i)
        else $error("logical flags not passed through");
    if (op_i[3:2] == 2'b10)
      p_no_write_r8: assert (!wr_o)
        else $error("compare or test wrote a result");
  end

endmodule

// File: tb/dp_alu_bench.sv
`timescale 1ns/1ps
module dp_alu_bench;

  typedef struct {
    logic [31:0] res;
    logic        wr, n, z, c, v;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] opa, opb, res;
  logic [3:0]  op;
  logic        ci, vi, shc, wr, n, z, c, v;

  dp_alu u_dp_alu (
    .opa_i(opa), .opb_i(opb), .op_i(op), .c_i(ci), .v_i(vi), .shc_i(shc),
    .res_o(res), .wr_o(wr), .n_o(n), .z_o(z), .c_o(c), .v_o(v)
  );

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;

  function automatic exp_t model(input logic [31:0] a, input logic [31:0] b,
                                 input logic [3:0] o, input logic cin,
                                 input logic vin, input logic sc, input string tag);
    exp_t e;
    longint sa, sb, ex;
    logic [32:0] wide;
    logic brw;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    brw = ~cin;
    e.tag = tag;
    e.wr  = !(o >= 4'd8 && o <= 4'd11);
    e.c   = sc;
    e.v   = vin;
    ex    = 0;
    case (o)
      4'd0, 4'd8:  e.res = a & b;
      4'd1, 4'd9:  e.res = a ^ b;
      4'd12:       e.res = a | b;
      4'd13:       e.res = b;
      4'd14:       e.res = a & ~b;
      4'd15:       e.res = ~b;
      4'd4, 4'd11: begin wide = {1'b0,a} + {1'b0,b}; e.res = wide[31:0]; e.c = wide[32]; ex = sa + sb; end
      4'd5:        begin wide = {1'b0,a} + {1'b0,b} + {32'd0,cin}; e.res = wide[31:0]; e.c = wide[32]; ex = sa + sb + longint'(cin); end
      4'd2, 4'd10: begin e.res = a - b; e.c = ({1'b0,a} >= {1'b0,b}); ex = sa - sb; end
      4'd3:        begin e.res = b - a; e.c = ({1'b0,b} >= {1'b0,a}); ex = sb - sa; end
      4'd6:        begin e.res = a - b - {31'd0,brw}; e.c = ({1'b0,a} >= {1'b0,b} + {32'd0,brw}); ex = sa - sb - longint'(brw); end
      default:     begin e.res = b - a - {31'd0,brw}; e.c = ({1'b0,b} >= {1'b0,a} + {32'd0,brw}); ex = sb - sa - longint'(brw); end
    endcase
    if (o >= 4'd2 && o <= 4'd7 || o == 4'd10 || o == 4'd11)
      e.v = (ex > 64'sd2147483647) || (ex < -64'sd2147483648);
    e.n = e.res[31];
    e.z = (e.res == 32'd0);
    return e;
  endfunction

  task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic [3:0] o,
                       input logic cin, input logic vin, input logic sc, input string tag);
    @(negedge clk);
    opa = a; opb = b; op = o; ci = cin; vi = vin; shc = sc;
    q.push_back(model(a, b, o, cin, vin, sc, tag));
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (res !== e.res || wr !== e.wr || n !== e.n || z !== e.z || c !== e.c || v !== e.v) begin
          fails++;
          $display("FAIL %s op=%0d: got res=%h wr=%b nzcv=%b%b%b%b, expected res=%h wr=%b nzcv=%b%b%b%b",
                   e.tag, op, res, wr, n, z, c, v, e.res, e.wr, e.n, e.z, e.c, e.v);
        end
      end
    end
  end

  initial begin : watchdog
    #1000000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : driver
    logic [31:0] lfsr;
    logic [32:0] lo;
    opa = '0; opb = '0; op = 4'd0; ci = 0; vi = 0; shc = 0;
    // idle inputs: AND of zeros, Z set, write high (R6, R8)
    drive(32'd0, 32'd0, 4'd0, 0, 0, 0, "R6 idle");
    // R1 logical
    drive(32'hF0F0_1234, 32'h0FF0_FF00, 4'd0, 0, 0, 1, "R1 and");
    drive(32'hF0F0_1234, 32'h0FF0_FF00, 4'd1, 1, 1, 0, "R1 eor");
    drive(32'hF0F0_1234, 32'h0FF0_FF00, 4'd12, 0, 1, 1, "R1 orr");
    // R2 moves and clear
    drive(32'h1111_1111, 32'h8000_0001, 4'd13, 0, 0, 1, "R2 mov");
    drive(32'h1111_1111, 32'h0000_0000, 4'd15, 1, 0, 0, "R2 mvn");
    drive(32'hFFFF_FFFF, 32'h00FF_00F0, 4'd14, 0, 1, 0, "R2 bic");
    // R3 add and carry
    drive(32'hFFFF_FFFF, 32'd1, 4'd4, 0, 0, 0, "R3 add carry out");
    drive(32'd5, 32'd7, 4'd5, 1, 0, 0, "R3 adc carry in");
    drive(32'hFFFF_FFFE, 32'd1, 4'd5, 1, 0, 0, "R3 adc wrap");
    // R4 subtract family, carry = no borrow
    drive(32'd10, 32'd3, 4'd2, 0, 0, 0, "R4 sub no borrow");
    drive(32'd3, 32'd10, 4'd2, 1, 0, 0, "R4 sub borrow");
    drive(32'd3, 32'd10, 4'd3, 0, 0, 0, "R4 rsb swapped");
    drive(32'd10, 32'd3, 4'd6, 0, 0, 0, "R4 sbc borrow in");
    drive(32'd10, 32'd10, 4'd6, 0, 0, 0, "R4 sbc borrow out");
    drive(32'd3, 32'd10, 4'd7, 0, 0, 0, "R4 rsc borrow in");
    drive(32'd7, 32'd7, 4'd2, 0, 0, 0, "R4 sub equal");
    // R5 overflow
    drive(32'h7FFF_FFFF, 32'd1, 4'd4, 0, 0, 0, "R5 add ovf");
    drive(32'h8000_0000, 32'd1, 4'd2, 0, 0, 0, "R5 sub ovf");
    drive(32'h8000_0000, 32'h8000_0000, 4'd11, 0, 0, 0, "R5 cmn ovf");
    drive(32'd1, 32'h8000_0000, 4'd3, 1, 0, 0, "R5 rsb ovf");
    // R7 logical flag pass-through
    drive(32'h8000_0000, 32'h8000_0000, 4'd0, 0, 1, 1, "R7 and flags");
    drive(32'hFFFF_FFFF, 32'd1, 4'd13, 1, 0, 0, "R7 mov flags");
    // R8 compare and test
    drive(32'hAAAA_5555, 32'h5555_AAAA, 4'd8, 0, 1, 1, "R8 tst");
    drive(32'hAAAA_5555, 32'hAAAA_5555, 4'd9, 0, 0, 1, "R8 teq");
    drive(32'd3, 32'd10, 4'd10, 1, 0, 0, "R8 cmp");
    drive(32'hFFFF_FFFF, 32'd1, 4'd11, 0, 0, 0, "R8 cmn");
    // R9 64-bit chains
    lo = {1'b0, 32'hFFFF_FFF0} + {1'b0, 32'h0000_0020};
    drive(32'hFFFF_FFF0, 32'h0000_0020, 4'd4, 0, 0, 0, "R9 add low");
    drive(32'h0000_0001, 32'h0000_0002, 4'd5, lo[32], 0, 0, "R9 adc high");
    drive(32'h0000_0010, 32'h0000_0020, 4'd2, 0, 0, 0, "R9 sub low");
    drive(32'h0000_0005, 32'h0000_0002, 4'd6, 1'b0, 0, 0, "R9 sbc high");
    // mixed sweep, every code
    lfsr = 32'hACE1_2345;
    for (int i = 0; i < 256; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      drive(lfsr, {lfsr[15:0], lfsr[31:16]} ^ 32'h5A5A_0F0F, 4'(i), lfsr[3], lfsr[7], lfsr[11],
            "R6 sweep");
    end
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule